// File: doc/BRIEF.md
# Eight-Slot Fast Signalling Mailbox

This block passes short messages from one processor to another, one 32-bit word at a time. It has eight independent slots. A sender stores a word by writing it to a slot. The same write marks that slot as pending in a shared status register. The receiver owns an enable register, and the block drives a single interrupt line towards the receiver. The receiver's handler reads the status, acknowledges a slot by writing a one to its bit in a write-one-to-clear register, and then reads the slot word.

There is no acknowledge path back to the sender and no sender-side interrupt. Software finds slot n through bit n+9 of the status, enable and clear registers, so those bit positions are fixed by the interface. The slot addresses are fixed in the same way.

All access goes through one register port. Writes take effect at the clock edge on which write-enable is sampled high. Reads are combinational from the address.

Top module: `fast_mbox`

## Requirements
- R1: After reset, every slot word, every status bit, every enable bit and the interrupt output are zero.
- R2: A write to byte address 0x8C + 4·n (n = 0..7) stores the write data in slot n. A read at that address returns the stored word from the cycle after the write.
- R3: A write to slot n sets bit n+9 of the status register, which is read at address 0xC8. The other status bits keep their values.
- R4: The receiver enable register at address 0xC0 keeps bits 9..16 of the written data and reads zero in every other bit. The interrupt is high exactly when some status bit n+9 and enable bit n+9 are both set.
- R5: A write to address 0xC4 clears every status bit n+9 for which data bit n+9 is one. It leaves the status bits whose data bit is zero unchanged, and it does not alter any slot word.
- R6: Writing a slot whose status bit is already set replaces the word and leaves the bit set.
- R7: Status bits change only through slot writes and clear writes. Writes to the status address or to unmapped addresses change no state. Unmapped addresses read as zero, and status and enable bits outside 9..16 read as zero.
- R8: The interrupt output and the read data reflect a write in the first cycle after the clock edge that samples that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Byte address of the register access |
| wrEn | input | 1 | Write strobe, sampled at the rising clock edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Receiver interrupt |

## Verification
A wrong status bit appears at the ports in two ways. A read at 0xC8 shows it in the cycle after the faulty edge. When its enable bit is set, the interrupt line also shows it in that same cycle, so a set or clear that is lost or lands on the wrong slot is exposed within one cycle.

A corrupted slot word stays hidden until that slot is read. For that reason, the bench compares the read data at every address it drives, on every cycle, against a behavioural model. The same comparison reveals a bit-offset error in the enable or clear path as soon as the wrongly placed bit gates or clears a pending slot.

// File: rtl/fast_mbox_pkg.sv
package fast_mbox_pkg;
  parameter int SLOTS = 8;

  typedef struct packed {
    logic [SLOTS-1:0] slotWr;
    logic [SLOTS-1:0] slotRd;
    logic             enWr;
    logic             enRd;
    logic             clrWr;
    logic             statRd;
  } mbox_strobe_t;
endpackage

// File: rtl/fast_mbox_ctrl.sv
module fast_mbox_ctrl
  import fast_mbox_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 8'h8C,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'hC0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'hC4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hC8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output mbox_strobe_t      strobe
);
  logic [SLOTS-1:0] slotHit;

  for (genvar k = 0; k < SLOTS; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] SLOT_ADDR = SLOT_BASE + ADDR_W'(k * 4);
    assign slotHit[k] = (addr == SLOT_ADDR);
  end

  always_comb begin
    strobe.slotWr = wrEn ? slotHit : '0;
    strobe.slotRd = slotHit;
    strobe.enWr   = wrEn && (addr == EN_ADDR);
    strobe.enRd   = (addr == EN_ADDR);
    strobe.clrWr  = wrEn && (addr == CLR_ADDR);
    strobe.statRd = (addr == STAT_ADDR);
  end
endmodule

// File: rtl/fast_mbox_dp.sv
module fast_mbox_dp
  import fast_mbox_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BIT_OFS = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [SLOTS-1:0]  slotStat,
  output logic [SLOTS-1:0]  slotEn,
  output logic              irq
);
  logic [DATA_W-1:0] slotWord [SLOTS];
  logic [SLOTS-1:0]  statNext;

  always_comb begin
    statNext = slotStat;
    if (strobe.clrWr) statNext = statNext & ~wrData[BIT_OFS +: SLOTS];
    statNext = statNext | strobe.slotWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SLOTS; k++) slotWord[k] <= '0;
      slotStat <= '0;
      slotEn   <= '0;
    end else begin
      for (int k = 0; k < SLOTS; k++)
        if (strobe.slotWr[k]) slotWord[k] <= wrData;
      slotStat <= statNext;
      if (strobe.enWr) slotEn <= wrData[BIT_OFS +: SLOTS];
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < SLOTS; k++)
      if (strobe.slotRd[k]) rdData = slotWord[k];
    if (strobe.enRd)   rdData[BIT_OFS +: SLOTS] = slotEn;
    if (strobe.statRd) rdData[BIT_OFS +: SLOTS] = slotStat;
  end

  assign irq = |(slotStat & slotEn);
endmodule

// File: rtl/fast_mbox.sv
module fast_mbox
  import fast_mbox_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                BIT_OFS   = 9,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 8'h8C,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'hC0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'hC4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hC8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  mbox_strobe_t     strobe;
  logic [SLOTS-1:0] slotStat;
  logic [SLOTS-1:0] slotEn;

  fast_mbox_ctrl #(
    .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE), .EN_ADDR(EN_ADDR),
    .CLR_ADDR(CLR_ADDR), .STAT_ADDR(STAT_ADDR)
  ) i_ctrl (
    .addr(addr), .wrEn(wrEn), .strobe(strobe)
  );

  fast_mbox_dp #(.DATA_W(DATA_W), .BIT_OFS(BIT_OFS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .slotStat(slotStat), .slotEn(slotEn), .irq(irq)
  );
endmodule

// File: rtl/fast_mbox_chk.sv
module fast_mbox_chk
  import fast_mbox_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                BIT_OFS   = 9,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 8'h8C,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'hC4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              irq,
  input logic [SLOTS-1:0]  slotStat,
  input logic [SLOTS-1:0]  slotEn
);
  always @(posedge clk) begin
    if (!rstN) begin
      // R1
      reset_state_chk: assert (slotStat == '0 && slotEn == '0 && !irq);
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] SA = SLOT_BASE + ADDR_W'(k * 4);

    // R3
    slot_sets_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == SA) |=> slotStat[k]);

    // R5
    clr_drops_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == CLR_ADDR && wrData[BIT_OFS + k]) |=> !slotStat[k]);

    // R7
    stat_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(slotStat[k]) |-> $past(wrEn && addr == SA));
  end

  // R4
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotEn == '0) |-> !irq);

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(slotStat) && $stable(slotEn)));
endmodule

bind fast_mbox fast_mbox_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_OFS(BIT_OFS),
  .SLOT_BASE(SLOT_BASE), .CLR_ADDR(CLR_ADDR)
) i_fast_mbox_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .irq(irq), .slotStat(slotStat), .slotEn(slotEn)
);

// File: tb/test_fast_mbox.sv
module test_fast_mbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Behavioural reference model
  logic [31:0] mSlot [8];
  logic [31:0] mStat, mEn;
  localparam logic [31:0] FMASK = 32'h0001_FE00;

  always #2 clk = ~clk;

  fast_mbox i_fast_mbox (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic int slotIdx(input logic [7:0] a);
    if (a >= 8'h8C && a <= 8'hA8 && a[1:0] == 2'b00) return (int'(a) - 'h8C) / 4;
    return -1;
  endfunction

  function automatic logic [31:0] modelRd(input logic [7:0] a);
    int s = slotIdx(a);
    if (s >= 0) return mSlot[s];
    if (a == 8'hC0) return mEn;
    if (a == 8'hC8) return mStat;
    return 32'h0;
  endfunction

  function automatic string reqOf(input logic [7:0] a);
    if (slotIdx(a) >= 0) return "R2";
    if (a == 8'hC0) return "R4";
    if (a == 8'hC8) return "R3";
    return "R7";
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 8; k++) mSlot[k] = 32'h0;
      mStat = 32'h0;
      mEn = 32'h0;
    end else if (wrEn) begin
      if (slotIdx(addr) >= 0) begin
        mSlot[slotIdx(addr)] = wrData;
        mStat = mStat | (32'h1 << (slotIdx(addr) + 9));
      end else if (addr == 8'hC0) mEn = wrData & FMASK;
      else if (addr == 8'hC4) mStat = mStat & ~(wrData & FMASK);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model (R8 timing included)
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(irq == ((mStat & mEn) != 0), "R4/R8 irq", {31'h0, irq}, {31'h0, (mStat & mEn) != 0});
      check(rdData == modelRd(addr), reqOf(addr), rdData, modelRd(addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    addr = a; wrEn = 1'b0;
    @(negedge clk);
    check(rdData == exp, req, rdData, exp);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    for (int k = 0; k < 8; k++) rdChk(8'(8'h8C + 4 * k), 32'h0, "R1 slot");
    rdChk(8'hC8, 32'h0, "R1 status");
    rdChk(8'hC0, 32'h0, "R1 enable");
    check(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);

    // R2, R3: store and flag, interrupt still masked
    wr(8'h98, 32'hDEAD_BEEF);
    check(irq == 1'b0, "R4 masked", {31'h0, irq}, 32'h0);
    rdChk(8'h98, 32'hDEAD_BEEF, "R2 slot3");
    rdChk(8'hC8, 32'h0000_1000, "R3 status bit12");

    // R4: enable keeps bits 9..16 only
    wr(8'hC0, 32'hFFFF_FFFF);
    check(irq == 1'b1, "R4 irq on", {31'h0, irq}, 32'h1);
    rdChk(8'hC0, FMASK, "R4 enable mask");

    // R6: overwrite pending slot
    wr(8'h98, 32'h1234_5678);
    rdChk(8'h98, 32'h1234_5678, "R6 word replaced");
    rdChk(8'hC8, 32'h0000_1000, "R6 bit kept");

    // R5: zero clear has no effect, then targeted clear
    wr(8'hC4, 32'h0000_0000);
    rdChk(8'hC8, 32'h0000_1000, "R5 zero clear");
    wr(8'hC4, 32'h0000_1000);
    rdChk(8'hC8, 32'h0, "R5 cleared");
    rdChk(8'h98, 32'h1234_5678, "R5 word kept");
    check(irq == 1'b0, "R5 irq off", {31'h0, irq}, 32'h0);

    // R7: writes to status and unmapped addresses
    wr(8'hC8, 32'hFFFF_FFFF);
    rdChk(8'hC8, 32'h0, "R7 status write ignored");
    wr(8'h10, 32'hA5A5_A5A5);
    rdChk(8'h10, 32'h0, "R7 unmapped read");
    rdChk(8'hC8, 32'h0, "R7 unmapped write ignored");

    // R8: irq one cycle after the write edge
    wr(8'hA8, 32'h0000_0007);
    check(irq == 1'b1, "R8 irq timing", {31'h0, irq}, 32'h1);

    // R4: per-slot gating
    wr(8'hC0, 32'h0000_0200);
    check(irq == 1'b0, "R4 slot7 gated", {31'h0, irq}, 32'h0);
    wr(8'h8C, 32'h0000_0001);
    check(irq == 1'b1, "R4 slot0 enabled", {31'h0, irq}, 32'h1);
    rdChk(8'hC8, 32'h0001_0200, "R3 two bits");

    // Random traffic, model-compared every cycle
    for (int i = 0; i < 400; i++) begin
      int sel = int'($urandom_range(0, 11));
      logic [7:0] a;
      if (sel < 8) a = 8'(8'h8C + 4 * sel);
      else if (sel == 8) a = 8'hC0;
      else if (sel == 9) a = 8'hC4;
      else if (sel == 10) a = 8'hC8;
      else a = 8'h04;
      if ($urandom_range(0, 2) == 0) rdChk(a, modelRd(a), reqOf(a));
      else wr(a, $urandom);
    end
    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule